// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates a small set of interrupt sources for an 8-bit processor core. Each source has a pending flag, which a one-cycle event pulse sets, and an enable bit of its own. A single global enable gates every source. The request to the core is raised when at least one source is pending, that source is enabled, and the global enable is 1.

When the core signals that it is ready while the request is high, the controller accepts the interrupt. It selects the pending and enabled source with the lowest index and registers that source's program-memory vector. In the same clock edge it clears the global enable and the serviced source's flag. A return strobe from the core turns the global enable back on. Software can also turn it on inside a handler, which allows nested interrupts.

Software reaches the controller through a small write port. One address loads the enable mask, one clears flags by writing 1s, and one loads the global enable. The flag, enable and global-enable states are brought out so they can be read.

Top module: `irq_vector_arb`

## Requirements
- R1: Source bit i is mapped as 0 = external request 0, 1 = external request 1, 2 = port low-level input, 3 = timer 0 overflow, 4 = analog comparator. On acceptance `vec_addr` becomes VEC_BASE + i, giving 0x001 to 0x005 by default. Address 0x000 is reserved for reset and is never produced by an acceptance.
- R2: When more than one source is pending and enabled, the one with the lowest bit index is serviced.
- R3: `irq_req` is 1 only when the global enable is 1 and at least one source has both its flag and its enable bit set. Sources whose enable bit is 0 are never serviced.
- R4: Acceptance happens when `irq_req` and `core_ready` are both 1 in a cycle. In the next cycle `vec_valid` is 1 for exactly one cycle, `vec_addr` holds the vector, and the global enable is 0.
- R5: Acceptance clears the serviced source's flag at the same edge and leaves every other flag unchanged.
- R6: A `reti` pulse sets the global enable to 1 at the next edge. If an acceptance happens in the same cycle, the acceptance wins and the global enable goes to 0.
- R7: A write with `cfg_addr` 0 loads the enable mask from `cfg_wdata`. A write with `cfg_addr` 1 clears each flag whose `cfg_wdata` bit is 1 and leaves flags whose bit is 0 unchanged. A write with `cfg_addr` 2 loads the global enable from `cfg_wdata[0]`, which allows nesting inside a handler. A write with `cfg_addr` 3 changes nothing.
- R8: A `src_evt` pulse sets its flag whether or not the source is enabled. If an event and a clear (software or acceptance) hit the same flag in the same cycle, the flag ends up set.
- R9: Synchronous reset clears all flags, all enable bits, the global enable, `vec_valid` and `vec_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_evt | input | NUM_SRC | One-cycle event pulses, one per source |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 enable mask, 1 flag clear, 2 global enable |
| cfg_wdata | input | NUM_SRC | Register write data |
| core_ready | input | 1 | Core can take an interrupt this cycle |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core (combinational) |
| vec_valid | output | 1 | One-cycle pulse marking a new vector |
| vec_addr | output | VEC_W | Vector address of the serviced source |
| flag_o | output | NUM_SRC | Pending flags |
| en_o | output | NUM_SRC | Individual enable bits |
| gie_o | output | 1 | Global enable |

## Verification
The bound checker examines every cycle. It checks that each vector pulse follows an accepted request, that the vector lies in the source range, and that no enabled source of lower index was pending. It also checks that the global enable is low while a vector pulse is present, that the serviced flag is cleared, that event pulses set their flags, and that the return strobe sets the global enable. The bench scenarios cover what the checker cannot see as a property: the exact sequence of vectors for a given set of pending flags, write-1-to-clear with mixed data bits, a write to the unused address having no effect, the return strobe losing to a simultaneous acceptance, nesting through a software write, and the values left by reset.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   typedef enum logic [1:0] {
      CFG_ENABLE  = 2'd0,
      CFG_FLAGCLR = 2'd1,
      CFG_GLOBAL  = 2'd2,
      CFG_UNUSED  = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int NUM_SRC = 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] flag_o
);
   // one register per source; a set beats a clear in the same cycle
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
      logic q;
      always_ff @(posedge clk) begin
         if (rst)           q <= 1'b0;
         else if (set_i[g]) q <= 1'b1;
         else if (clr_i[g]) q <= 1'b0;
      end
      assign flag_o[g] = q;
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NUM_SRC = 5,
   parameter int IDX_W   = 3
) (
   input  logic [NUM_SRC-1:0] req_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o,
   output logic [NUM_SRC-1:0] sel_o
);
   // sel_o is one-hot on the lowest set bit of req_i
   logic [NUM_SRC-1:0] blocked;
   assign blocked[0] = 1'b0;
   for (genvar g = 1; g < NUM_SRC; g++) begin : g_chain
      assign blocked[g] = blocked[g-1] | req_i[g-1];
   end
   assign sel_o = req_i & ~blocked;
   assign any_o = |req_i;

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (sel_o[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_gie_ctl.sv
module irq_gie_ctl (
   input  logic clk,
   input  logic rst,
   input  logic take_i,
   input  logic reti_i,
   input  logic sw_we_i,
   input  logic sw_val_i,
   output logic gie_o
);
   // precedence: acceptance, then return strobe, then software write
   always_ff @(posedge clk) begin
      if (rst)          gie_o <= 1'b0;
      else if (take_i)  gie_o <= 1'b0;
      else if (reti_i)  gie_o <= 1'b1;
      else if (sw_we_i) gie_o <= sw_val_i;
   end
endmodule

// File: rtl/irq_vector_arb.sv
module irq_vector_arb #(
   parameter int NUM_SRC  = 5,
   parameter int VEC_W    = 10,
   parameter int VEC_BASE = 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] src_evt,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_addr,
   input  logic [NUM_SRC-1:0] cfg_wdata,
   input  logic               core_ready,
   input  logic               reti,
   output logic               irq_req,
   output logic               vec_valid,
   output logic [VEC_W-1:0]   vec_addr,
   output logic [NUM_SRC-1:0] flag_o,
   output logic [NUM_SRC-1:0] en_o,
   output logic               gie_o
);
   import irq_arb_pkg::*;

   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   initial begin
      assert (NUM_SRC >= 1) else $error("NUM_SRC must be at least 1");
      assert (VEC_BASE >= 1) else $error("VEC_BASE must leave room for the reset vector");
      assert (VEC_BASE + NUM_SRC <= (1 << VEC_W)) else $error("VEC_W too narrow for the vectors");
   end

   cfg_sel_e           sel;
   logic               we_en, we_clr, we_gie;
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] live;
   logic               any_live;
   logic [IDX_W-1:0]   win_idx;
   logic [NUM_SRC-1:0] win_sel;
   logic               take;
   logic [NUM_SRC-1:0] clr_mask;

   assign sel    = cfg_sel_e'(cfg_addr);
   assign we_en  = cfg_we && (sel == CFG_ENABLE);
   assign we_clr = cfg_we && (sel == CFG_FLAGCLR);
   assign we_gie = cfg_we && (sel == CFG_GLOBAL);

   always_ff @(posedge clk) begin
      if (rst)        en_q <= '0;
      else if (we_en) en_q <= cfg_wdata;
   end

   assign live = flag_o & en_q;

   irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
      .req_i (live),
      .any_o (any_live),
      .idx_o (win_idx),
      .sel_o (win_sel)
   );

   assign irq_req  = gie_o & any_live;
   assign take     = irq_req & core_ready;
   assign clr_mask = (we_clr ? cfg_wdata : '0) | (take ? win_sel : '0);

   irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
      .clk    (clk),
      .rst    (rst),
      .set_i  (src_evt),
      .clr_i  (clr_mask),
      .flag_o (flag_o)
   );

   irq_gie_ctl u_gie (
      .clk      (clk),
      .rst      (rst),
      .take_i   (take),
      .reti_i   (reti),
      .sw_we_i  (we_gie),
      .sw_val_i (cfg_wdata[0]),
      .gie_o    (gie_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         vec_valid <= 1'b0;
         vec_addr  <= '0;
      end else begin
         vec_valid <= take;
         if (take) vec_addr <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
      end
   end

   assign en_o = en_q;
endmodule

// File: rtl/irq_vector_arb_chk.sv
module irq_vector_arb_chk #(
   parameter int NUM_SRC  = 5,
   parameter int VEC_W    = 10,
   parameter int VEC_BASE = 1
) (
   input logic               clk,
   input logic               rst,
   input logic [NUM_SRC-1:0] src_evt,
   input logic               core_ready,
   input logic               reti,
   input logic               irq_req,
   input logic               vec_valid,
   input logic [VEC_W-1:0]   vec_addr,
   input logic [NUM_SRC-1:0] flag_o,
   input logic [NUM_SRC-1:0] en_o,
   input logic               gie_o
);
   logic [NUM_SRC-1:0] srv_mask;
   logic [NUM_SRC-1:0] below_mask;
   logic               acc;

   assign acc        = irq_req && core_ready;
   assign srv_mask   = NUM_SRC'(1) << (vec_addr - VEC_W'(VEC_BASE));
   assign below_mask = srv_mask - NUM_SRC'(1);

   a_r1_vec_range: assert property (@(posedge clk) disable iff (rst)
      vec_valid |-> (vec_addr >= VEC_W'(VEC_BASE) && vec_addr < VEC_W'(VEC_BASE + NUM_SRC)));

   a_r2_lowest_wins: assert property (@(posedge clk) disable iff (rst)
      vec_valid |-> ((($past(flag_o & en_o) & below_mask) == '0) &&
                     (($past(flag_o & en_o) & srv_mask) != '0)));

   a_r3_vec_after_req: assert property (@(posedge clk) disable iff (rst)
      vec_valid |-> $past(acc));

   a_r4_acc_gives_vec: assert property (@(posedge clk) disable iff (rst)
      acc |=> vec_valid);

   a_r4_gie_low_on_vec: assert property (@(posedge clk) disable iff (rst)
      vec_valid |-> !gie_o);

   a_r5_served_flag_cleared: assert property (@(posedge clk) disable iff (rst)
      vec_valid |-> ((flag_o & srv_mask & ~$past(src_evt)) == '0));

   a_r6_reti_sets_gie: assert property (@(posedge clk) disable iff (rst)
      (reti && !acc) |=> gie_o);

   a_r8_evt_sets_flag: assert property (@(posedge clk) disable iff (rst)
      (|src_evt) |=> ((flag_o & $past(src_evt)) == $past(src_evt)));
endmodule

bind irq_vector_arb irq_vector_arb_chk #(
   .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .src_evt    (src_evt),
   .core_ready (core_ready),
   .reti       (reti),
   .irq_req    (irq_req),
   .vec_valid  (vec_valid),
   .vec_addr   (vec_addr),
   .flag_o     (flag_o),
   .en_o       (en_o),
   .gie_o      (gie_o)
);

// File: tb/sim_irq_vector_arb.sv
`timescale 1ns/1ps
module sim_irq_vector_arb;
   localparam int N  = 5;
   localparam int VW = 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  src_evt = '0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_addr = '0;
   logic [N-1:0]  cfg_wdata = '0;
   logic          core_ready = 1'b0;
   logic          reti = 1'b0;
   logic          irq_req, vec_valid, gie_o;
   logic [VW-1:0] vec_addr;
   logic [N-1:0]  flag_o, en_o;

   int n_run  = 0;
   int n_fail = 0;
   int exp_q[$];
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_vector_arb #(.NUM_SRC(N), .VEC_W(VW), .VEC_BASE(1)) u0 (
      .clk(clk), .rst(rst), .src_evt(src_evt), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .core_ready(core_ready),
      .reti(reti), .irq_req(irq_req), .vec_valid(vec_valid),
      .vec_addr(vec_addr), .flag_o(flag_o), .en_o(en_o), .gie_o(gie_o)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: every vector pulse is compared to the oldest expected item
   always @(negedge clk) begin
      if (!done && !rst && vec_valid) begin
         if (exp_q.size() == 0) chk("R4 unexpected vector", 32'(vec_addr), 32'hFFFF);
         else chk("R1/R2 vector", 32'(vec_addr), 32'(exp_q.pop_front()));
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic pulse_evt(logic [N-1:0] m);
      src_evt = m; step(); src_evt = '0;
   endtask

   task automatic cfg_write(logic [1:0] a, logic [N-1:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; step();
      cfg_we = 1'b0; cfg_wdata = '0;
   endtask

   task automatic do_reti();
      reti = 1'b1; step(); reti = 1'b0;
   endtask

   // driver: push the expected vector, then raise core_ready for one cycle
   task automatic accept(int exp_vec, bit with_reti);
      exp_q.push_back(exp_vec);
      chk("R3 request before accept", 32'(irq_req), 32'd1);
      core_ready = 1'b1; reti = with_reti; step();
      core_ready = 1'b0; reti = 1'b0;
   endtask

   initial begin
      #(20ns * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst = 1'b0;
      step();
      // R9: reset state
      chk("R9 flags", 32'(flag_o), 0);
      chk("R9 enables", 32'(en_o), 0);
      chk("R9 gie", 32'(gie_o), 0);
      chk("R9 vec_valid", 32'(vec_valid), 0);
      chk("R9 vec_addr", 32'(vec_addr), 0);

      // R8: event sets flag while disabled; R3: no request
      pulse_evt(5'b00001);
      chk("R8 flag set while disabled", 32'(flag_o), 32'b00001);
      chk("R3 no req when disabled", 32'(irq_req), 0);

      cfg_write(2'd0, 5'b11111);
      chk("R7 enable mask load", 32'(en_o), 32'b11111);
      chk("R3 no req without gie", 32'(irq_req), 0);
      cfg_write(2'd2, 5'b00001);
      chk("R7 gie load", 32'(gie_o), 1);
      chk("R3 req with gie", 32'(irq_req), 1);

      // R2/R1: service order by index
      pulse_evt(5'b10110);
      chk("R8 flags", 32'(flag_o), 32'b10111);
      accept(1, 0);
      chk("R4 gie cleared", 32'(gie_o), 0);
      chk("R5 only served flag", 32'(flag_o), 32'b10110);
      chk("R4 req drops", 32'(irq_req), 0);
      do_reti();
      chk("R6 reti sets gie", 32'(gie_o), 1);
      accept(2, 0);
      chk("R5 flags", 32'(flag_o), 32'b10100);
      do_reti();
      accept(3, 0);
      do_reti();
      accept(5, 0);
      chk("R5 all served", 32'(flag_o), 0);

      // R3: disabled sources are skipped
      cfg_write(2'd0, 5'b10000);
      pulse_evt(5'b01111);
      do_reti();
      chk("R3 masked no req", 32'(irq_req), 0);
      pulse_evt(5'b10000);
      accept(5, 0);
      chk("R3 masked flags kept", 32'(flag_o), 32'b01111);

      // R7 nesting by software, then R6 accept beats reti
      cfg_write(2'd2, 5'b00001);
      chk("R7 nested gie", 32'(gie_o), 1);
      cfg_write(2'd0, 5'b11111);
      accept(1, 1);
      chk("R6 accept wins over reti", 32'(gie_o), 0);
      chk("R5 flags after nest", 32'(flag_o), 32'b01110);

      // R7 write-1-to-clear
      cfg_write(2'd1, 5'b00110);
      chk("R7 w1c", 32'(flag_o), 32'b01000);
      src_evt = 5'b01000;
      cfg_write(2'd1, 5'b01000);
      src_evt = '0;
      chk("R8 event beats clear", 32'(flag_o), 32'b01000);
      cfg_write(2'd1, 5'b01000);
      chk("R7 w1c last", 32'(flag_o), 0);

      // R7: unused address changes nothing
      cfg_write(2'd3, 5'b11111);
      chk("R7 addr3 enables", 32'(en_o), 32'b11111);
      chk("R7 addr3 flags", 32'(flag_o), 0);
      chk("R7 addr3 gie", 32'(gie_o), 0);

      // R9: reset mid-run
      pulse_evt(5'b00011);
      do_reti();
      rst = 1'b1; step(); rst = 1'b0;
      chk("R9 flags after reset", 32'(flag_o), 0);
      chk("R9 gie after reset", 32'(gie_o), 0);
      chk("R9 en after reset", 32'(en_o), 0);
      chk("R9 req after reset", 32'(irq_req), 0);

      step();
      chk("R4 all vectors seen", 32'(exp_q.size()), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule